// File: doc/BRIEF.md
# Shadow Mask Pixel Modulator

This block darkens and brightens an RGB pixel stream in a repeating tile, the way the phosphor triads of a tube display do. Two small phase counters follow the raster. One counts active pixels within a line and the other counts lines within a frame. Each counter wraps at its own programmable period, so the tile can be anywhere from 1x1 to 16x16. The pair of phases picks one entry from a 256-entry pattern table. That entry gives each colour channel a gain, and the channel is scaled by it with saturation.

Software fills the pattern table over a 32-bit write-only register bus in its own clock domain. The video side reads the table on the pixel clock. A configuration word on the pixel side turns the effect on or off and sets both wrap periods. Sync and data-enable travel through the same number of registers as the colour data, so the outputs stay aligned. When the effect is off, the pixels pass through with the same delay.

Top module: `shmask_modulator`

## Requirements
- R1: The horizontal phase is cleared by `line_start`. Each cycle with `pix_act` high and `line_start` low moves it by one. The cycle after it equals the horizontal period it returns to 0. Cycles without `pix_act` leave it unchanged.
- R2: `frame_start` clears the vertical phase. The first `line_start` after a frame start, or one in the same cycle as it, leaves the phase at 0. Each later `line_start` advances it by one, and it wraps to 0 after it equals the vertical period.
- R3: The pattern table has 256 entries of 11 bits. The entry index is vertical phase in bits 7:4 and horizontal phase in bits 3:0. A bus write to word addresses 0x100 to 0x1FF stores `bus_wdata[10:0]` in entry `bus_addr[7:0]`. Writes to any other address, and write data bits 31:11, have no effect on the table.
- R4: Entry bit 10 selects red, bit 9 selects green and bit 8 selects blue. A selected channel gets gain 16 + bits[7:4]. An unselected channel gets gain bits[3:0].
- R5: When enabled, each channel output is (channel x gain) >> 4, so a gain of 16 leaves the channel unchanged. A result of 256 or more is output as 0xFF.
- R6: With the enable flag clear, every channel comes out equal to its input, whatever the table holds.
- R7: A pixel, with its `de_in`, `hs_in` and `vs_in`, sampled at one pixel-clock edge appears on the outputs after the fifth edge counted from that one, and not earlier.
- R8: In `mask_cfg`, bit 15 is the enable flag, bits 19:16 are the horizontal period and bits 23:20 are the vertical period. A period value p gives a tile p+1 wide or tall.
- R9: During reset and until new data arrives, all outputs are 0. After reset both phases are 0, and the next `line_start` behaves as the first line of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock |
| pix_rst_n | input | 1 | Active-low reset, pixel domain |
| bus_clk | input | 1 | Register bus clock |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 10 | Bus word address |
| bus_wdata | input | 32 | Bus write data |
| mask_cfg | input | 32 | Enable and wrap periods (pixel domain) |
| frame_start | input | 1 | One-cycle frame start strobe |
| line_start | input | 1 | One-cycle line start strobe |
| pix_act | input | 1 | Active output pixel qualifier, advances horizontal phase |
| de_in | input | 1 | Data enable, delayed to output |
| hs_in | input | 1 | Horizontal sync, delayed to output |
| vs_in | input | 1 | Vertical sync, delayed to output |
| r_in | input | 8 | Red in |
| g_in | input | 8 | Green in |
| b_in | input | 8 | Blue in |
| r_out | output | 8 | Red out |
| g_out | output | 8 | Green out |
| b_out | output | 8 | Blue out |
| de_out | output | 1 | Delayed data enable |
| hs_out | output | 1 | Delayed horizontal sync |
| vs_out | output | 1 | Delayed vertical sync |

## Verification
Single table entries are tried with one, two and three selected channels and with both zero and maximum nibbles. The inputs are chosen so that the outputs separate a boosted channel from a dimmed one and truncation from rounding, and they land on either side of the 255/256 saturation edge. A second pass loads every entry with a value that encodes its own index. Feeding a flat grey then turns each output into a readout of the two phases, which separates wrap at the period from wrap at 16, clears from line and frame strobes, and the held first line. Writes outside the table window and the passthrough with a saturating entry show which paths do not reach the output.

// File: rtl/shm_pkg.sv
package shm_pkg;
    localparam int PH_W         = 4;
    localparam int CH_W         = 8;
    localparam int NIB_W        = 4;
    localparam int NCH          = 3;
    localparam int ENT_W        = NCH + 2 * NIB_W;
    localparam int GAIN_W       = NIB_W + 1;
    localparam int PROD_W       = CH_W + GAIN_W;
    localparam int TBL_AW       = 2 * PH_W;
    localparam int TBL_DEPTH    = 1 << TBL_AW;
    localparam int BUS_AW       = 10;
    localparam int BUS_DW       = 32;
    localparam int TBL_REGION   = 1;
    localparam int CFG_W        = 32;
    localparam int CFG_EN_BIT   = 15;
    localparam int CFG_HPER_LSB = 16;
    localparam int CFG_VPER_LSB = 20;
    localparam int RD_LAT       = 2;
    localparam int SCALE_LAT    = 3;
    localparam int PIPE_LAT     = RD_LAT + SCALE_LAT;

    typedef logic [PH_W-1:0]  phase_t;
    typedef logic [CH_W-1:0]  chan_t;
    typedef logic [ENT_W-1:0] entry_t;

    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
    } sync_t;
endpackage

// File: rtl/shm_phase_gen.sv
module shm_phase_gen
    import shm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   line_start,
    input  logic   frame_start,
    input  logic   pix_act,
    input  phase_t hper,
    input  phase_t vper,
    output phase_t xph,
    output phase_t yph
);
    typedef struct packed {
        phase_t x;
        phase_t y;
        logic   first;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (line_start) begin
            st_d.x = '0;
        end else if (pix_act) begin
            st_d.x = (st_q.x == hper) ? '0 : st_q.x + 1'b1;
        end
        if (frame_start) begin
            st_d.y     = '0;
            st_d.first = !line_start;
        end else if (line_start) begin
            if (st_q.first) begin
                st_d.first = 1'b0;
            end else begin
                st_d.y = (st_q.y == vper) ? '0 : st_q.y + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{x: '0, y: '0, first: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign xph = st_q.x;
    assign yph = st_q.y;

    AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (xph == '0)); // R1
    AST_X_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_act && !line_start && xph == hper) |=> (xph == '0)); // R1
    AST_X_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_act && !line_start) |=> $stable(xph)); // R1
    AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (yph == '0)); // R2
    AST_Y_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && !frame_start) |=> $stable(yph)); // R2
endmodule

// File: rtl/shm_table.sv
module shm_table
    import shm_pkg::*;
(
    input  logic              bus_clk,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic [TBL_AW-1:0] rd_addr,
    output entry_t            rd_data
);
    entry_t mem [TBL_DEPTH];

    logic wr_hit;
    assign wr_hit = bus_we
                 && (bus_addr[BUS_AW-1:TBL_AW] == (BUS_AW-TBL_AW)'(TBL_REGION));

    always_ff @(posedge bus_clk) begin
        if (wr_hit) begin
            mem[bus_addr[TBL_AW-1:0]] <= bus_wdata[ENT_W-1:0];
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata[BUS_DW-1:ENT_W];

    typedef struct packed {
        logic [TBL_AW-1:0] addr;
        entry_t            data;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    always_comb begin
        rd_d      = rd_q;
        rd_d.addr = rd_addr;
        rd_d.data = mem[rd_q.addr];
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q.data;
endmodule

// File: rtl/shm_chan_scale.sv
module shm_chan_scale
    import shm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sel,
    input  logic [NIB_W-1:0] hi,
    input  logic [NIB_W-1:0] lo,
    input  chan_t            pix,
    output chan_t            pix_out
);
    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        chan_t             pix;
        logic [PROD_W-1:0] prod;
        chan_t             out;
    } sc_st_t;

    sc_st_t st_d, st_q;
    logic [CH_W:0] scaled;
    chan_t         pix_s;

    assign scaled = st_q.prod[PROD_W-1:NIB_W];
    assign pix_s  = st_q.pix;

    always_comb begin
        st_d      = st_q;
        st_d.gain = sel ? {1'b1, hi} : {1'b0, lo};
        st_d.pix  = pix;
        if (en) begin
            st_d.prod = PROD_W'(st_q.pix) * PROD_W'(st_q.gain);
        end else begin
            st_d.prod = PROD_W'({st_q.pix, {NIB_W{1'b0}}});
        end
        st_d.out = scaled[CH_W] ? {CH_W{1'b1}} : scaled[CH_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_out = st_q.out;

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        scaled[CH_W] |=> (pix_out == {CH_W{1'b1}})); // R5
    AST_BYPASS_ID: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> ##2 (pix_out == $past(pix_s, 2))); // R6
endmodule

// File: rtl/shmask_modulator.sv
module shmask_modulator
    import shm_pkg::*;
(
    input  logic              pix_clk,
    input  logic              pix_rst_n,
    input  logic              bus_clk,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic [CFG_W-1:0]  mask_cfg,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              pix_act,
    input  logic              de_in,
    input  logic              hs_in,
    input  logic              vs_in,
    input  logic [CH_W-1:0]   r_in,
    input  logic [CH_W-1:0]   g_in,
    input  logic [CH_W-1:0]   b_in,
    output logic [CH_W-1:0]   r_out,
    output logic [CH_W-1:0]   g_out,
    output logic [CH_W-1:0]   b_out,
    output logic              de_out,
    output logic              hs_out,
    output logic              vs_out
);
    logic   cfg_en;
    phase_t cfg_hper, cfg_vper;
    assign cfg_en   = mask_cfg[CFG_EN_BIT];
    assign cfg_hper = mask_cfg[CFG_HPER_LSB +: PH_W];
    assign cfg_vper = mask_cfg[CFG_VPER_LSB +: PH_W];

    logic unused_cfg;
    assign unused_cfg = ^{mask_cfg[CFG_W-1:CFG_VPER_LSB+PH_W], mask_cfg[CFG_EN_BIT-1:0]};

    phase_t xph, yph;
    entry_t ent;

    shm_phase_gen u_phase (
        .clk         (pix_clk),
        .rst_n       (pix_rst_n),
        .line_start  (line_start),
        .frame_start (frame_start),
        .pix_act     (pix_act),
        .hper        (cfg_hper),
        .vper        (cfg_vper),
        .xph         (xph),
        .yph         (yph)
    );

    shm_table u_table (
        .bus_clk   (bus_clk),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rd_clk    (pix_clk),
        .rd_rst_n  (pix_rst_n),
        .rd_addr   ({yph, xph}),
        .rd_data   (ent)
    );

    typedef struct packed {
        logic  [NCH-1:0][CH_W-1:0] pix0;
        logic  [NCH-1:0][CH_W-1:0] pix1;
        sync_t [PIPE_LAT-1:0]      sy;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [NCH-1:0][CH_W-1:0] rgb_in_w, rgb_out_w;
    sync_t sync_in;

    assign rgb_in_w = {r_in, g_in, b_in};
    assign sync_in  = '{de: de_in, hs: hs_in, vs: vs_in};

    always_comb begin
        st_d      = st_q;
        st_d.pix0 = rgb_in_w;
        st_d.pix1 = st_q.pix0;
        st_d.sy   = {st_q.sy[PIPE_LAT-2:0], sync_in};
    end

    always_ff @(posedge pix_clk or negedge pix_rst_n) begin
        if (!pix_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            shm_chan_scale u_scale (
                .clk     (pix_clk),
                .rst_n   (pix_rst_n),
                .en      (cfg_en),
                .sel     (ent[2*NIB_W + c]),
                .hi      (ent[NIB_W +: NIB_W]),
                .lo      (ent[0 +: NIB_W]),
                .pix     (st_q.pix1[c]),
                .pix_out (rgb_out_w[c])
            );
        end
    endgenerate

    assign {r_out, g_out, b_out} = rgb_out_w;
    assign de_out = st_q.sy[PIPE_LAT-1].de;
    assign hs_out = st_q.sy[PIPE_LAT-1].hs;
    assign vs_out = st_q.sy[PIPE_LAT-1].vs;

    AST_DE_ALIGN: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        de_out == $past(de_in, PIPE_LAT)); // R7
endmodule

// File: tb/tb_shmask_modulator.sv
module tb_shmask_modulator;
    logic pix_clk = 1'b0;
    logic bus_clk = 1'b0;
    always #2 pix_clk = ~pix_clk;
    always #3 bus_clk = ~bus_clk;

    logic        pix_rst_n, bus_we, frame_start, line_start, pix_act;
    logic        de_in, hs_in, vs_in, de_out, hs_out, vs_out;
    logic [9:0]  bus_addr;
    logic [31:0] bus_wdata, mask_cfg;
    logic [7:0]  r_in, g_in, b_in, r_out, g_out, b_out;

    shmask_modulator dut (
        .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .bus_clk(bus_clk),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .mask_cfg(mask_cfg), .frame_start(frame_start), .line_start(line_start),
        .pix_act(pix_act), .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in),
        .r_in(r_in), .g_in(g_in), .b_in(b_in),
        .r_out(r_out), .g_out(g_out), .b_out(b_out),
        .de_out(de_out), .hs_out(hs_out), .vs_out(vs_out)
    );

    // {entry, rgb in, rgb expected}
    localparam logic [58:0] VEC [6] = '{
        {11'h410, 24'h808080, 24'h880000},
        {11'h00F, 24'hFF1001, 24'hEF0F00},
        {11'h7F0, 24'hFF0820, 24'hFF0F3E},
        {11'h20C, 24'h4055C8, 24'h305596},
        {11'h108, 24'h21FE7F, 24'h107F7F},
        {11'h610, 24'hF1F055, 24'hFFFF00}
    };

    int checks = 0;
    int errors = 0;
    logic [23:0] res;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge bus_clk);
        bus_we = 1'b0;
    endtask

    task automatic line_pulse();
        @(negedge pix_clk); line_start = 1'b1;
        @(negedge pix_clk); line_start = 1'b0;
    endtask

    task automatic frame_pulse();
        @(negedge pix_clk); frame_start = 1'b1;
        @(negedge pix_clk); frame_start = 1'b0;
    endtask

    task automatic push_px(input logic [23:0] rgb, output logic [23:0] o);
        @(negedge pix_clk);
        pix_act = 1'b1; de_in = 1'b1; {r_in, g_in, b_in} = rgb;
        @(negedge pix_clk);
        pix_act = 1'b0; de_in = 1'b0; {r_in, g_in, b_in} = 24'h0;
        repeat (4) @(negedge pix_clk);
        o = {r_out, g_out, b_out};
    endtask

    // Table holds 0x400 | index: R boosted by y, G and B dimmed to x
    task automatic px_phase(input int ex, input int ey, input string req);
        logic [23:0] o;
        push_px(24'h101010, o);
        chk(req, o, {8'(16 + ey), 8'(ex), 8'(ex)});
    endtask

    initial begin
        repeat (100000) @(posedge pix_clk);
        errors++;
        $display("FAIL watchdog R7 act=running exp=finished");
        finish_run();
    end

    initial begin
        pix_rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        mask_cfg = '0; frame_start = 1'b0; line_start = 1'b0; pix_act = 1'b0;
        de_in = 1'b0; hs_in = 1'b0; vs_in = 1'b0;
        r_in = '0; g_in = '0; b_in = '0;
        repeat (4) @(negedge pix_clk);
        chk("R9 outputs in reset", {r_out, g_out, b_out, de_out, hs_out, vs_out}, 32'h0);
        pix_rst_n = 1'b1;
        repeat (3) @(negedge pix_clk);
        chk("R9 outputs after reset", {r_out, g_out, b_out, de_out, hs_out, vs_out}, 32'h0);

        // R4 R5: vector walk with a 1x1 tile (period 0)
        mask_cfg = 32'h0000_8000;
        for (int i = 0; i < 6; i++) begin
            bus_wr(10'h100, {21'h0, VEC[i][58:48]});
            push_px(VEC[i][47:24], res);
            chk($sformatf("R4 R5 vector %0d", i), res, VEC[i][23:0]);
        end

        // R3: high data bits and out-of-window addresses ignored
        bus_wr(10'h100, 32'hFFFF_F80F);
        bus_wr(10'h000, 32'h0000_07F0);
        bus_wr(10'h200, 32'h0000_07F0);
        bus_wr(10'h300, 32'h0000_07F0);
        push_px(24'h101010, res);
        chk("R3 ignored writes", res, 24'h0F0F0F);

        // R6 passthrough, R5 zero gain
        bus_wr(10'h100, 32'h0);
        mask_cfg = 32'h0;
        push_px(24'h123456, res);
        chk("R6 disabled passthrough", res, 24'h123456);
        mask_cfg = 32'h0000_8000;
        push_px(24'h123456, res);
        chk("R5 zero gain", res, 24'h000000);
        bus_wr(10'h100, 32'h7F0);
        mask_cfg = 32'h0;
        push_px(24'hFFFFFF, res);
        chk("R6 disabled with boosting entry", res, 24'hFFFFFF);

        // R7 latency of sync and data enable
        @(negedge pix_clk); de_in = 1'b1; hs_in = 1'b1; vs_in = 1'b1;
        @(negedge pix_clk); de_in = 1'b0; hs_in = 1'b0; vs_in = 1'b0;
        repeat (3) @(negedge pix_clk);
        chk("R7 not before fifth edge", {29'h0, de_out, hs_out, vs_out}, 32'h0);
        @(negedge pix_clk);
        chk("R7 at fifth edge", {29'h0, de_out, hs_out, vs_out}, 32'h7);
        @(negedge pix_clk);
        chk("R7 single cycle", {29'h0, de_out, hs_out, vs_out}, 32'h0);

        // R1 R2 R8: phases read back through an index-coded table
        for (int i = 0; i < 256; i++) bus_wr(10'(10'h100 + i), 32'h400 | i);
        mask_cfg = 32'h0012_8000;
        frame_pulse();
        line_pulse();
        px_phase(0, 0, "R1 R8 first pixel");
        px_phase(1, 0, "R1 step");
        px_phase(2, 0, "R1 at period");
        px_phase(0, 0, "R1 R8 wrap after period");
        px_phase(1, 0, "R1 step after wrap");
        line_pulse();
        px_phase(0, 1, "R1 R2 line advance");
        px_phase(1, 1, "R2 row held");
        line_pulse();
        px_phase(0, 0, "R2 R8 vertical wrap");
        frame_pulse();
        line_pulse();
        px_phase(0, 0, "R2 first line held");
        line_pulse();
        px_phase(0, 1, "R2 second line");
        @(negedge pix_clk); frame_start = 1'b1; line_start = 1'b1;
        @(negedge pix_clk); frame_start = 1'b0; line_start = 1'b0;
        px_phase(0, 0, "R2 coincident strobes");
        line_pulse();
        px_phase(0, 1, "R2 advance after coincident");
        mask_cfg = 32'h0003_8000;
        frame_pulse();
        line_pulse();
        px_phase(0, 0, "R8 wider tile");
        px_phase(1, 0, "R8 wider tile");
        px_phase(2, 0, "R8 wider tile");
        px_phase(3, 0, "R8 wider tile x3");
        px_phase(0, 0, "R1 R8 wrap at 3");

        finish_run();
    end
endmodule